// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block turns a packed timing word into the strobe waveform of one byte transfer on a NAND flash bus. A request carries a direction. The block then walks through these phases in order: a chip-enable settle phase, an optional bus turnaround gap, a strobe-low phase and a strobe-high phase. It ends with a one-cycle completion pulse. The length of every phase is a cycle count taken from a field of the timing word.

The block also runs a separate delay after each completion. When that delay runs out, it samples the flash ready/busy line into a ready flag. The timing word is captured when a request is accepted, so software may rewrite it at any time without disturbing a transfer that is already running. Command and address sequencing, data movement and error correction belong to other blocks.

Top module: `nand_strobe_timer`

## Requirements
- R1: While reset is asserted and after it is released with no request, `nwe_n` and `nre_n` are 1, `xfer_done` is 0 and `ready_flag` is 0.
- R2: Timing word fields, least significant first: write-low count at bits 3:0, write-high count at bits 7:4, read-low count at bits 11:8, read-high count at bits 15:12, turnaround count at bits 18:16, ready-sample delay at bits 23:19 and chip-enable settle count at bits 25:24. Bits above 25 are ignored.
- R3: A field value N holds its phase for exactly N+1 clock cycles, so a value of 0 still gives one cycle.
- R4: When `start` is high in an idle cycle with `start_rd` = 0, the next cycles hold both strobes high for the settle phase. `nwe_n` is then low for the write-low phase and high for the write-high phase. `nre_n` stays high throughout.
- R5: With `start_rd` = 1 the same sequence runs with `nre_n` in place of `nwe_n`, and the read-low and read-high fields set the widths. `nwe_n` stays high throughout.
- R6: A turnaround phase of turnaround-count+1 cycles, with both strobes high, is inserted between the settle and low phases only when a write follows a read. A read-to-read, write-to-write or write-to-read pair gets no gap. The first transfer after reset is treated as following a write.
- R7: `xfer_done` is high for exactly one cycle, the cycle right after the strobe-high phase, and the block is idle in the cycle after that. A `start` seen while a transfer is in progress, including its done cycle, is ignored.
- R8: `ready_flag` takes the value of `rb_n` at the clock edge that comes ready-delay+1 edges after the edge that ends the done cycle. It holds its value at all other times.
- R9: Every field is captured at the edge that accepts the request. Changing `timing_word` during a transfer has no effect on that transfer.
- R10: `nwe_n` and `nre_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | WORD_W (32) | Packed phase counts |
| start | input | 1 | Request one byte transfer |
| start_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| rb_n | input | 1 | Flash ready/busy line, 1 = ready |
| nwe_n | output | 1 | Write strobe, active low |
| nre_n | output | 1 | Read strobe, active low |
| xfer_done | output | 1 | One-cycle completion pulse |
| ready_flag | output | 1 | Last sampled ready/busy value |

## Verification
Assertions check on every cycle that the two strobes are never low together and that the completion pulse lasts one cycle and always follows the strobe-high phase. They also check that the captured timing stays frozen during a transfer, that a turnaround phase appears only after a read when a write is running, that the phase counter steps down by one, and that the ready flag changes only when the sample window expires. Only the bench scenarios can show that each phase has the width its field asks for and that fields sit at the right bit positions. The same holds for the exact edge on which the ready line is sampled and for mid-transfer rewrites of the word leaving the current waveform untouched. The bench shows these by comparing every cycle against a queue-based model.

// File: rtl/nst_pkg.sv
`timescale 1ns/1ps
package nst_pkg;

    localparam int CNT_W = 5;

    localparam int WLO_LSB = 0;   localparam int WLO_W = 4;
    localparam int WHI_LSB = 4;   localparam int WHI_W = 4;
    localparam int RLO_LSB = 8;   localparam int RLO_W = 4;
    localparam int RHI_LSB = 12;  localparam int RHI_W = 4;
    localparam int TRN_LSB = 16;  localparam int TRN_W = 3;
    localparam int BSY_LSB = 19;  localparam int BSY_W = 5;
    localparam int CEA_LSB = 24;  localparam int CEA_W = 2;
    localparam int USED_W  = CEA_LSB + CEA_W;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CEA  = 3'd1,
        PH_TURN = 3'd2,
        PH_LOW  = 3'd3,
        PH_HIGH = 3'd4,
        PH_DONE = 3'd5
    } phase_e;

    typedef struct packed {
        logic [WLO_W-1:0] wr_lo;
        logic [WHI_W-1:0] wr_hi;
        logic [RLO_W-1:0] rd_lo;
        logic [RHI_W-1:0] rd_hi;
        logic [TRN_W-1:0] turn;
        logic [BSY_W-1:0] busy;
        logic [CEA_W-1:0] cea;
    } timing_t;

    function automatic timing_t unpack_timing(input logic [USED_W-1:0] w);
        timing_t t;
        t.wr_lo = w[WLO_LSB +: WLO_W];
        t.wr_hi = w[WHI_LSB +: WHI_W];
        t.rd_lo = w[RLO_LSB +: RLO_W];
        t.rd_hi = w[RHI_LSB +: RHI_W];
        t.turn  = w[TRN_LSB +: TRN_W];
        t.busy  = w[BSY_LSB +: BSY_W];
        t.cea   = w[CEA_LSB +: CEA_W];
        return t;
    endfunction

endpackage

// File: rtl/nst_phase_ctr.sv
`timescale 1ns/1ps
module nst_phase_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3: a loaded count walks down one step per cycle
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nst_busy_sampler.sv
`timescale 1ns/1ps
module nst_busy_sampler #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic [W-1:0] delay,
    input  logic         rb_n,
    output logic         ready_flag
);
    typedef struct packed {
        logic         armed;
        logic [W-1:0] cnt;
        logic         ready;
    } smp_t;

    smp_t d, q;

    always_comb begin
        d = q;
        if (q.armed && q.cnt == '0) begin
            d.ready = rb_n;
            d.armed = 1'b0;
        end else if (q.armed) begin
            d.cnt = q.cnt - 1'b1;
        end
        if (arm) begin
            d.armed = 1'b1;
            d.cnt   = delay;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_flag = q.ready;

    // R8: the flag moves only when a sample window runs out
    p_ready_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.ready) |-> $past(q.armed && q.cnt == '0));

endmodule

// File: rtl/nand_strobe_timer.sv
`timescale 1ns/1ps
module nand_strobe_timer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] timing_word,
    input  logic              start,
    input  logic              start_rd,
    input  logic              rb_n,
    output logic              nwe_n,
    output logic              nre_n,
    output logic              xfer_done,
    output logic              ready_flag
);
    import nst_pkg::*;

    localparam int SPARE_W = WORD_W - USED_W;

    typedef struct packed {
        phase_e  ph;
        timing_t tm;
        logic    is_rd;
        logic    last_rd;
    } seq_t;

    seq_t d, q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expired;
    timing_t          fresh;

    generate
        if (SPARE_W > 0) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^timing_word[WORD_W-1:USED_W];
        end
    endgenerate

    assign fresh = unpack_timing(timing_word[USED_W-1:0]);

    always_comb begin
        d      = q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (q.ph)
            PH_IDLE: if (start) begin
                d.tm    = fresh;
                d.is_rd = start_rd;
                d.ph    = PH_CEA;
                ld      = 1'b1;
                ld_val  = CNT_W'(fresh.cea);
            end
            PH_CEA: if (expired) begin
                ld = 1'b1;
                if (q.last_rd && !q.is_rd) begin
                    d.ph   = PH_TURN;
                    ld_val = CNT_W'(q.tm.turn);
                end else begin
                    d.ph   = PH_LOW;
                    ld_val = q.is_rd ? CNT_W'(q.tm.rd_lo) : CNT_W'(q.tm.wr_lo);
                end
            end
            PH_TURN: if (expired) begin
                d.ph   = PH_LOW;
                ld     = 1'b1;
                ld_val = q.is_rd ? CNT_W'(q.tm.rd_lo) : CNT_W'(q.tm.wr_lo);
            end
            PH_LOW: if (expired) begin
                d.ph   = PH_HIGH;
                ld     = 1'b1;
                ld_val = q.is_rd ? CNT_W'(q.tm.rd_hi) : CNT_W'(q.tm.wr_hi);
            end
            PH_HIGH: if (expired) begin
                d.ph = PH_DONE;
            end
            PH_DONE: begin
                d.last_rd = q.is_rd;
                d.ph      = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, tm: '0, is_rd: 1'b0, last_rd: 1'b0};
        else        q <= d;
    end

    nst_phase_ctr #(.W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    nst_busy_sampler #(.W(BSY_W)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (q.ph == PH_DONE),
        .delay      (q.tm.busy),
        .rb_n       (rb_n),
        .ready_flag (ready_flag)
    );

    assign nwe_n     = !(q.ph == PH_LOW && !q.is_rd);
    assign nre_n     = !(q.ph == PH_LOW &&  q.is_rd);
    assign xfer_done = (q.ph == PH_DONE);

    // R10: strobes are mutually exclusive
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nwe_n && !nre_n));
    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);
    // R7: done always follows the high phase
    p_done_after_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(q.ph) == PH_HIGH);
    // R9: captured timing frozen while busy
    p_word_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != PH_IDLE && $past(q.ph) != PH_IDLE) |-> $stable(q.tm));
    // R6: turnaround only when a write follows a read
    p_turn_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_TURN) |-> (q.last_rd && !q.is_rd));

endmodule

// File: tb/tb_nand_strobe_timer.sv
`timescale 1ns/1ps
module tb_nand_strobe_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_word = '0;
    logic        start = 1'b0;
    logic        start_rd = 1'b0;
    logic        rb_n = 1'b1;
    logic        nwe_n, nre_n, xfer_done, ready_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #10 clk = ~clk;

    nand_strobe_timer dut (
        .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
        .start(start), .start_rd(start_rd), .rb_n(rb_n),
        .nwe_n(nwe_n), .nre_n(nre_n), .xfer_done(xfer_done),
        .ready_flag(ready_flag)
    );

    // reference model: queue of expected {nwe_n, nre_n, done}
    logic [2:0] exp_q[$];
    int  m_busy_pend = 0;
    int  m_bcnt = 0;
    bit  m_last_rd = 0;
    bit  m_ready = 0;

    task automatic build(input logic [31:0] w, input bit rd);
        int cea, trn, lo, hi;
        cea = int'(w[25:24]); trn = int'(w[18:16]);
        lo  = rd ? int'(w[11:8]) : int'(w[3:0]);
        hi  = rd ? int'(w[15:12]) : int'(w[7:4]);
        for (int i = 0; i <= cea; i++) exp_q.push_back(3'b110);
        if (m_last_rd && !rd)
            for (int i = 0; i <= trn; i++) exp_q.push_back(3'b110);
        for (int i = 0; i <= lo; i++) exp_q.push_back(rd ? 3'b100 : 3'b010);
        for (int i = 0; i <= hi; i++) exp_q.push_back(3'b110);
        exp_q.push_back(3'b111);
        m_busy_pend = int'(w[23:19]);
        m_last_rd = rd;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            exp_q.delete(); m_bcnt = 0; m_last_rd = 0; m_ready = 0;
        end else begin
            logic [2:0] e;
            if (m_bcnt > 0) begin
                m_bcnt--;
                if (m_bcnt == 0) m_ready = rb_n;
            end
            if (exp_q.size() == 0) begin
                if (start) build(timing_word, start_rd);
            end else begin
                e = exp_q.pop_front();
                if (e[0]) m_bcnt = m_busy_pend + 1;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) if (rst_n) begin
        logic [2:0] e;
        e = (exp_q.size() == 0) ? 3'b110 : exp_q[0];
        check("R4 nwe_n", nwe_n, e[2]);
        check("R5 nre_n", nre_n, e[1]);
        check("R7 done", xfer_done, e[0]);
        check("R8 ready", ready_flag, m_ready);
        check("R10 exclusive", !nwe_n && !nre_n, 1'b0);
    end

    // ready line pattern so the sample edge matters
    always @(negedge clk) rb_n <= cyc[1] ^ cyc[4];

    // one transfer; measure lead, low and total cycles before done
    task automatic xfer(input logic [31:0] w, input bit rd, input bit rewrite,
                        input bit hold_start, output int lead, output int low,
                        output int total);
        @(negedge clk);
        timing_word = w; start = 1'b1; start_rd = rd;
        @(negedge clk);
        if (!hold_start) start = 1'b0;
        if (rewrite) timing_word = ~w;
        lead = 0; low = 0; total = 0;
        while (!xfer_done && total < 200) begin
            if ((rd ? nre_n : nwe_n) == 1'b0) low++;
            else if (low == 0) lead++;
            total++;
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_xfer(input string req, input logic [31:0] w, input bit rd,
                               input bit turn, input bit rewrite, input bit hold);
        int lead, low, total, e_lead, e_lo, e_hi;
        xfer(w, rd, rewrite, hold, lead, low, total);
        e_lead = int'(w[25:24]) + 1 + (turn ? int'(w[18:16]) + 1 : 0);
        e_lo = (rd ? int'(w[11:8]) : int'(w[3:0])) + 1;
        e_hi = (rd ? int'(w[15:12]) : int'(w[7:4])) + 1;
        check_int({req, " lead"}, lead, e_lead);
        check_int({req, " low"}, low, e_lo);
        check_int({req, " total"}, total, e_lead + e_lo + e_hi);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 nwe_n", nwe_n, 1'b1);
        check("R1 nre_n", nre_n, 1'b1);
        check("R1 done", xfer_done, 1'b0);
        check("R1 ready", ready_flag, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle nwe_n", nwe_n, 1'b1);

        // R2 R3 R4: write with distinct fields, first after reset
        expect_xfer("R2 R4 write", 32'h02_1A_7_5_3_2, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3: all-zero fields give one-cycle phases
        expect_xfer("R3 zero", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5: read
        expect_xfer("R5 read", 32'h0108_A4F0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6: write after read inserts turnaround
        expect_xfer("R6 rd->wr", 32'h0105_0021, 1'b0, 1'b1, 1'b0, 1'b0);
        // R6: write after write, read after write: no gap
        expect_xfer("R6 wr->wr", 32'h0107_0011, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_xfer("R6 wr->rd", 32'h0007_3300, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_xfer("R6 rd->rd", 32'h0007_1200, 1'b1, 1'b0, 1'b0, 1'b0);
        // R9: rewrite mid-transfer has no effect (also upper bits ignored, R2)
        expect_xfer("R9 rewrite", 32'hFC06_0F0F, 1'b0, 1'b1, 1'b1, 1'b0);
        // R7: start held through the transfer is ignored until idle
        expect_xfer("R7 held start", 32'h0100_0203, 1'b0, 1'b0, 1'b0, 1'b1);
        // R8: long sample delay, then idle until the window expires
        expect_xfer("R8 delay", 32'h00F8_0101, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        expect_xfer("R8 short", 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        // back-to-back sweep of field values
        for (int k = 0; k < 24; k++) begin
            logic [31:0] w;
            w = {6'd0, 2'(k), 5'(k * 3), 3'(k), 4'(k + 1), 4'(k * 5), 4'(k * 7), 4'(k)};
            xfer(w, k[0], k[2], 1'b0, cyc, cyc, cyc);
        end
        repeat (40) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule